// File: doc/BRIEF.md
# Dual-Plane Ring Buffer Fill Monitor

This block follows a producer as it writes video lines into two circular buffers in memory, one for the luma plane and one for the chroma plane. The consumer's read position for each plane arrives on input ports. Software programs each ring's lower and upper address bounds, the address step per line and the address step per frame, and two fill limits. Writing a ring's lower bound also moves that plane's producer position and frame base to the lower bound.

Each line-done pulse moves that plane's producer position forward by one line step, wrapping at the upper bound. A frame-start pulse moves both planes to the previous frame base plus one frame step. The block computes how far the producer leads the consumer within the ring. It flags almost-full and a live overflow for each plane, latches overflow per plane until software clears it, and pulses one shared event when a plane newly enters overflow.

Top module: `dual_ring_fill_monitor`

## Requirements
- R1: After reset, both producer positions, all sticky overflow bits and the event output are zero.
- R2: A configuration write with `cfg_sel` = {plane, field} loads the field of that plane. The plane bit is 0 for luma and 1 for chroma. The fields are 0 lower bound, 1 upper bound, 2 line step, 3 frame step, 4 almost-full limit and 5 overflow limit; fields 6 and 7 are ignored. Writing field 0 sets that plane's producer position and frame base to the written value on the next clock.
- R3: On a line-done pulse the producer position becomes position + line step. If that sum is at or above the upper bound, the position becomes the sum minus (upper − lower). Without a pulse, a write or a frame start, the position holds.
- R4: A frame-start pulse sets each plane's frame base and producer position to base + frame step, wrapped as in R3. It takes priority over a line-done pulse in the same cycle.
- R5: Occupancy is position − read pointer when the position is at or above the read pointer, and otherwise position − read pointer + (upper − lower).
- R6: Almost-full of a plane is high exactly when its occupancy is greater than or equal to its almost-full limit.
- R7: Live overflow of a plane is high exactly when its occupancy is strictly greater than its overflow limit.
- R8: A plane's sticky overflow bit is set on the clock after live overflow is seen. It stays set until a clear pulse on a cycle in which live overflow of that plane is low; a set in the same cycle wins over the clear.
- R9: The event output is high for the one cycle following a clock at which some plane had live overflow while its sticky bit was still clear.
- R10: Line-done pulses, writes and read pointers of one plane do not change the other plane's position or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | {plane, field[2:0]} selecting the written register |
| cfg_wdata | input | AW | Configuration write data |
| line_done | input | 2 | Per-plane line written pulse (bit 0 luma, bit 1 chroma) |
| frame_start | input | 1 | New frame pulse for both planes |
| ovfl_clr | input | 1 | Clears the sticky overflow bits |
| y_rd_ptr | input | AW | Consumer read address, luma ring |
| c_rd_ptr | input | AW | Consumer read address, chroma ring |
| y_wr_ptr | output | AW | Producer position, luma ring |
| c_wr_ptr | output | AW | Producer position, chroma ring |
| y_occupancy | output | AW | Producer lead, luma ring |
| c_occupancy | output | AW | Producer lead, chroma ring |
| afull | output | 2 | Per-plane almost-full |
| ovfl_live | output | 2 | Per-plane live overflow |
| ovfl_sticky | output | 2 | Per-plane latched overflow |
| ovfl_event | output | 1 | One-cycle pulse on a newly latched overflow |

## Verification
The bench steps a line so that it lands exactly on the upper bound. A design that compares with strictly-greater would leave the position outside the ring instead of returning it to the lower bound. It places the read pointer ahead of the producer, where an occupancy without the modulo correction would wrap to a huge value and falsely overflow. It probes occupancy equal to each limit: a design that swaps ≥ and > flags almost-full one step late or overflow one step early. It also issues a clear while overflow is still live and a frame start together with a line pulse, where a wrong priority drops the latch or steps the position by the line step.

// File: rtl/dual_ring_fill_monitor.sv
module dual_ring_fill_monitor #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [1:0]    line_done,
  input  logic          frame_start,
  input  logic          ovfl_clr,
  input  logic [AW-1:0] y_rd_ptr,
  input  logic [AW-1:0] c_rd_ptr,
  output logic [AW-1:0] y_wr_ptr,
  output logic [AW-1:0] c_wr_ptr,
  output logic [AW-1:0] y_occupancy,
  output logic [AW-1:0] c_occupancy,
  output logic [1:0]    afull,
  output logic [1:0]    ovfl_live,
  output logic [1:0]    ovfl_sticky,
  output logic          ovfl_event
);
  localparam int NP = 2;

  logic [AW-1:0] rd  [NP];
  logic [AW-1:0] wp  [NP];
  logic [AW-1:0] occ [NP];

  assign rd[0] = y_rd_ptr;
  assign rd[1] = c_rd_ptr;
  assign y_wr_ptr = wp[0];
  assign c_wr_ptr = wp[1];
  assign y_occupancy = occ[0];
  assign c_occupancy = occ[1];

  function automatic logic [AW-1:0] ring_add(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                             input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, hi}) s = s - {1'b0, hi - lo};
    return s[AW-1:0];
  endfunction

  for (genvar p = 0; p < NP; p++) begin : g_plane
    logic [AW-1:0] lo, hi, lstep, fstep, af_lim, of_lim, ptr, base, span;
    logic          we_p;

    assign we_p = cfg_we && (cfg_sel[3] == (p == 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo <= '0; hi <= '0; lstep <= '0; fstep <= '0; af_lim <= '0; of_lim <= '0;
      end else if (we_p) begin
        case (cfg_sel[2:0])
          3'd0: lo     <= cfg_wdata;
          3'd1: hi     <= cfg_wdata;
          3'd2: lstep  <= cfg_wdata;
          3'd3: fstep  <= cfg_wdata;
          3'd4: af_lim <= cfg_wdata;
          3'd5: of_lim <= cfg_wdata;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr  <= '0;
        base <= '0;
      end else if (we_p && cfg_sel[2:0] == 3'd0) begin
        ptr  <= cfg_wdata;
        base <= cfg_wdata;
      end else if (frame_start) begin
        ptr  <= ring_add(base, fstep, lo, hi);
        base <= ring_add(base, fstep, lo, hi);
      end else if (line_done[p]) begin
        ptr  <= ring_add(ptr, lstep, lo, hi);
      end
    end

    assign span         = hi - lo;
    assign occ[p]       = (ptr >= rd[p]) ? ptr - rd[p] : ptr - rd[p] + span;
    assign afull[p]     = occ[p] >= af_lim;
    assign ovfl_live[p] = occ[p] > of_lim;
    assign wp[p]        = ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovfl_sticky <= '0;
      ovfl_event  <= 1'b0;
    end else begin
      ovfl_sticky <= (ovfl_sticky & ~{NP{ovfl_clr}}) | ovfl_live;
      ovfl_event  <= |(ovfl_live & ~ovfl_sticky);
    end
  end
endmodule

// File: rtl/dual_ring_fill_monitor_sva.sv
module dual_ring_fill_monitor_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    line_done,
  input logic          frame_start,
  input logic          ovfl_clr,
  input logic [AW-1:0] y_wr_ptr,
  input logic [AW-1:0] c_wr_ptr,
  input logic [1:0]    ovfl_live,
  input logic [1:0]    ovfl_sticky,
  input logic          ovfl_event
);
  p_hold_y_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !frame_start && !line_done[0]) |=> $stable(y_wr_ptr));

  p_hold_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !frame_start && !line_done[1]) |=> $stable(c_wr_ptr));

  p_live_latches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfl_live != 2'b00) |=> ((ovfl_sticky & $past(ovfl_live)) == $past(ovfl_live)));

  p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ovfl_clr |=> (($past(ovfl_sticky) & ~ovfl_sticky) == 2'b00));

  p_event_new_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovfl_live & ~ovfl_sticky) != 2'b00) |=> ovfl_event);

  p_event_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovfl_event |-> ((ovfl_sticky & ~$past(ovfl_sticky)) != 2'b00));
endmodule

bind dual_ring_fill_monitor dual_ring_fill_monitor_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .line_done(line_done),
  .frame_start(frame_start), .ovfl_clr(ovfl_clr), .y_wr_ptr(y_wr_ptr),
  .c_wr_ptr(c_wr_ptr), .ovfl_live(ovfl_live), .ovfl_sticky(ovfl_sticky),
  .ovfl_event(ovfl_event)
);

// File: tb/dual_ring_fill_monitor_tb.sv
module dual_ring_fill_monitor_tb;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam longint MSK = 64'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [3:0] cfg_sel = 0; logic [AW-1:0] cfg_wdata = 0;
  logic [1:0] line_done = 0; logic frame_start = 0, ovfl_clr = 0;
  logic [AW-1:0] y_rd_ptr = 0, c_rd_ptr = 0;
  logic [AW-1:0] y_wr_ptr, c_wr_ptr, y_occupancy, c_occupancy;
  logic [1:0] afull, ovfl_live, ovfl_sticky;
  logic ovfl_event;

  int tests = 0, fails = 0;
  longint m_lo[2], m_hi[2], m_ls[2], m_fs[2], m_at[2], m_ot[2], m_ptr[2], m_base[2];
  bit [1:0] m_sticky; bit m_evt;

  always #(CLK_NS/2) clk = ~clk;

  dual_ring_fill_monitor #(.AW(AW)) u_dut (.*);

  function automatic longint wrap(longint a, longint b, longint lo, longint hi);
    longint s = a + b;
    if (s >= hi) s = s - ((hi - lo) & MSK);
    return s & MSK;
  endfunction

  function automatic longint mocc(int p, longint rd);
    longint span = (m_hi[p] - m_lo[p]) & MSK;
    return (m_ptr[p] >= rd) ? (m_ptr[p] - rd) & MSK : (m_ptr[p] - rd + span) & MSK;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    longint rd[2]; bit [1:0] lv;
    #1;
    rd[0] = y_rd_ptr; rd[1] = c_rd_ptr;
    chk("R3 y position", y_wr_ptr, m_ptr[0]);
    chk("R10 c position", c_wr_ptr, m_ptr[1]);
    chk("R5 y occupancy", y_occupancy, mocc(0, rd[0]));
    chk("R5 c occupancy", c_occupancy, mocc(1, rd[1]));
    for (int p = 0; p < 2; p++) begin
      lv[p] = mocc(p, rd[p]) > m_ot[p];
      chk("R6 almost-full", afull[p], mocc(p, rd[p]) >= m_at[p]);
      chk("R7 live overflow", ovfl_live[p], lv[p]);
    end
    chk("R8 sticky", ovfl_sticky, m_sticky);
    chk("R9 event", ovfl_event, m_evt);
    m_evt = |(lv & ~m_sticky);
    m_sticky = (m_sticky & ~{2{ovfl_clr}}) | lv;
    for (int p = 0; p < 2; p++) begin
      if (cfg_we && cfg_sel[3] == (p == 1)) begin
        case (cfg_sel[2:0])
          3'd1: m_hi[p] = cfg_wdata;
          3'd2: m_ls[p] = cfg_wdata;
          3'd3: m_fs[p] = cfg_wdata;
          3'd4: m_at[p] = cfg_wdata;
          3'd5: m_ot[p] = cfg_wdata;
          default: ;
        endcase
      end
      if (cfg_we && cfg_sel[3] == (p == 1) && cfg_sel[2:0] == 0) begin
        m_lo[p] = cfg_wdata; m_ptr[p] = cfg_wdata; m_base[p] = cfg_wdata;
      end else if (frame_start) begin
        m_base[p] = wrap(m_base[p], m_fs[p], m_lo[p], m_hi[p]); m_ptr[p] = m_base[p];
      end else if (line_done[p]) begin
        m_ptr[p] = wrap(m_ptr[p], m_ls[p], m_lo[p], m_hi[p]);
      end
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 0; line_done = 0; frame_start = 0; ovfl_clr = 0;
  endtask

  task automatic wr(int p, int f, longint v);
    cfg_we = 1; cfg_sel = {p[0], f[2:0]}; cfg_wdata = v[AW-1:0];
    cycle();
    idle();
  endtask

  task automatic setup(int p, longint lo, longint hi, longint ls, longint fs, longint at, longint ot);
    wr(p, 1, hi); wr(p, 0, lo); wr(p, 2, ls); wr(p, 3, fs); wr(p, 4, at); wr(p, 5, ot);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 2; p++) begin
      m_lo[p] = 0; m_hi[p] = 0; m_ls[p] = 0; m_fs[p] = 0;
      m_at[p] = 0; m_ot[p] = 0; m_ptr[p] = 0; m_base[p] = 0;
    end
    m_sticky = 0; m_evt = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset y position", y_wr_ptr, 0);
    chk("R1 reset sticky", ovfl_sticky, 0);
    chk("R1 reset event", ovfl_event, 0);
    rst_n = 1;
    cycle();

    setup(0, 'h1000, 'h1100, 'h40, 'h80, 'h40, 'h80);
    setup(1, 'h2000, 'h2080, 'h20, 'h40, 'h30, 'h60);
    chk("R2 bottom write loads y position", y_wr_ptr, 'h1000);
    chk("R2 bottom write loads c position", c_wr_ptr, 'h2000);
    y_rd_ptr = 'h1000; c_rd_ptr = 'h2000;
    wr(0, 6, 'hDEAD);
    chk("R2 field 6 ignored", y_wr_ptr, 'h1000);
    line_done = 2'b01; cycle(); idle();
    chk("R10 luma pulse leaves chroma", c_wr_ptr, 'h2000);
    chk("R6 occupancy equal to limit", afull[0], 1);
    line_done = 2'b01; cycle(); idle();
    chk("R7 occupancy equal to limit", ovfl_live[0], 0);
    y_rd_ptr = 'h10C0; cycle();
    chk("R5 read ahead of producer", y_occupancy, 'hC0);
    chk("R7 above limit", ovfl_live[0], 1);
    ovfl_clr = 1; cycle(); idle();
    chk("R8 set wins over clear", ovfl_sticky[0], 1);
    y_rd_ptr = 'h1080; ovfl_clr = 1; cycle(); idle(); cycle();
    chk("R8 clear", ovfl_sticky[0], 0);
    line_done = 2'b01; cycle(); cycle(); idle();
    chk("R3 exact hit of upper bound wraps", y_wr_ptr, 'h1000);
    frame_start = 1; line_done = 2'b11; cycle(); idle();
    chk("R4 frame start over line pulse", y_wr_ptr, 'h1080);
    chk("R4 frame start chroma", c_wr_ptr, 'h2040);

    for (int k = 0; k < 6; k++) begin
      for (int p = 0; p < 2; p++) begin
        longint lo = longint'($urandom_range(0, 'hFFFF)) * 16;
        longint sz = $urandom_range(64, 4096);
        setup(p, lo, lo + sz, $urandom_range(1, sz - 1), $urandom_range(0, sz - 1),
              $urandom_range(0, sz - 1), $urandom_range(0, sz - 1));
      end
      for (int n = 0; n < 600; n++) begin
        line_done   = 2'($urandom_range(0, 3));
        frame_start = ($urandom_range(0, 49) == 0);
        ovfl_clr    = ($urandom_range(0, 19) == 0);
        y_rd_ptr    = AW'(m_lo[0] + $urandom_range(0, 32'(m_hi[0] - m_lo[0] - 1)));
        c_rd_ptr    = AW'(m_lo[1] + $urandom_range(0, 32'(m_hi[1] - m_lo[1] - 1)));
        cycle();
      end
      idle();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule